// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a processor virtual address into a physical address by looking up a single-level page table in memory. A base register, loaded through its own write port, locates the table. Each virtual address is split into a page number in its upper bits and a byte offset in its low `PAGE_BITS` bits. The block adds the page number to the base to get the entry address, reads that entry over a simple memory port, and checks the entry's control bits. It then returns either a physical address or a fault code.

An entry carries a frame number in bits [PTE_W-1:PAGE_BITS] and three control bits: present at bit 0, dirty at bit 1 and write-enable at bit 2. The first write the block allows to a clean page stores the entry back with the dirty bit set, and this happens before the response. The processor side takes one request at a time. A request is accepted only while the block is idle, and each request gets exactly one response pulse.

Top module: `vpage_xlate`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o and mem_req_o are 0.
- R2: The entry read uses address base + page number, taken modulo 2^PTE_W. The read is issued in the cycle after acceptance and is held steady until mem_ack_i.
- R3: A present entry that permits the access gives status 00 and a physical address of {frame, offset}, where the offset is passed through unchanged.
- R4: An entry with bit 0 clear gives status 01 (page fault) and physical address 0, whatever the request type and the other bits. Memory is not written.
- R5: A write request whose present entry has bit 2 clear gives status 10 (protection fault) and physical address 0. Memory is not written.
- R6: A permitted write to an entry with bit 1 clear causes exactly one memory write, to the entry's address, of the entry with bit 1 set. This write completes before the response.
- R7: A read request, or a write to an entry that already has bit 1 set, leaves memory unwritten.
- R8: req_ready_o is 1 only when the block is idle. A request presented while a walk is in progress is ignored and produces no response.
- R9: A base write affects only requests accepted after it. A walk already in progress keeps the entry address it computed at acceptance.
- R10: rsp_valid_o is a one-cycle pulse. It comes in the cycle after the last memory acknowledge of the walk, and the status code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Load the table base register |
| base_i | input | PTE_W | New table base value |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Block is idle and accepts a request |
| req_vaddr_i | input | VA_W | Virtual address |
| req_write_i | input | 1 | Request is a store |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_status_o | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rsp_paddr_o | output | PTE_W | Physical address (0 on fault) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | PTE_W | Entry address |
| mem_wdata_o | output | PTE_W | Entry write-back data |
| mem_rdata_i | input | PTE_W | Entry read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory access complete |

## Verification
The bench builds the block with its defaults: 32-bit virtual addresses, 12-bit page offsets and 32-bit entries. These values give 20-bit page numbers and a 20-bit frame field. They make two cases reachable: the offset extremes 000 and FFF, and the largest page number, whose sum with a high base wraps past 2^32 to a low entry address. The bench memory adds a configurable number of wait states. With these it holds walks open long enough to present competing requests and to change the base in the middle of a walk.

// File: rtl/vx_pkg.sv
package vx_pkg;
  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_DIRTY   = 1;
  localparam int unsigned PTE_WRITE   = 2;

  typedef enum logic [1:0] {
    XS_OK    = 2'b00,
    XS_PFLT  = 2'b01,
    XS_PROT  = 2'b10
  } xstat_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WBACK,
    ST_RESP
  } xstate_e;
endpackage

// File: rtl/vx_addr_gen.sv
module vx_addr_gen #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PTE_W     = 32
) (
  input  logic [VA_W-1:0]      vaddr_i,
  input  logic [PTE_W-1:0]     base_i,
  output logic [PAGE_BITS-1:0] offset_o,
  output logic [PTE_W-1:0]     entry_addr_o
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;

  logic [VPN_W-1:0] vpn;

  assign vpn          = vaddr_i[VA_W-1:PAGE_BITS];
  assign offset_o     = vaddr_i[PAGE_BITS-1:0];
  // modulo 2^PTE_W add
  assign entry_addr_o = base_i + PTE_W'(vpn);
endmodule

// File: rtl/vx_pte_eval.sv
module vx_pte_eval
  import vx_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PTE_W     = 32
) (
  input  logic [PTE_W-1:0]     pte_i,
  input  logic                 write_i,
  input  logic [PAGE_BITS-1:0] offset_i,
  output xstat_e               status_o,
  output logic [PTE_W-1:0]     paddr_o,
  output logic                 need_wb_o,
  output logic [PTE_W-1:0]     wb_data_o
);
  localparam int unsigned FRAME_W = PTE_W - PAGE_BITS;

  logic [FRAME_W-1:0] frame;
  assign frame = pte_i[PTE_W-1:PAGE_BITS];

  always_comb begin
    status_o  = XS_OK;
    paddr_o   = {frame, offset_i};
    need_wb_o = 1'b0;
    wb_data_o = pte_i;
    wb_data_o[PTE_DIRTY] = 1'b1;
    // presence checked before permission
    if (!pte_i[PTE_PRESENT]) begin
      status_o = XS_PFLT;
      paddr_o  = '0;
    end else if (write_i && !pte_i[PTE_WRITE]) begin
      status_o = XS_PROT;
      paddr_o  = '0;
    end else if (write_i && !pte_i[PTE_DIRTY]) begin
      need_wb_o = 1'b1;
    end
  end
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
  import vx_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PTE_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [PTE_W-1:0] base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_status_o,
  output logic [PTE_W-1:0] rsp_paddr_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PTE_W-1:0] mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic [PTE_W-1:0] mem_rdata_i,
  input  logic             mem_ack_i
);
  xstate_e                state_q;
  logic [PTE_W-1:0]       base_q;
  logic [PTE_W-1:0]       entry_q;
  logic [PAGE_BITS-1:0]   off_q;
  logic                   write_q;
  logic [PTE_W-1:0]       wb_data_q;
  xstat_e                 status_q;
  logic [PTE_W-1:0]       paddr_q;

  logic [PAGE_BITS-1:0]   off_d;
  logic [PTE_W-1:0]       entry_d;
  xstat_e                 eval_status;
  logic [PTE_W-1:0]       eval_paddr;
  logic                   eval_wb;
  logic [PTE_W-1:0]       eval_wb_data;
  logic                   accept;

  vx_addr_gen #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PTE_W(PTE_W)
  ) i_addr (
    .vaddr_i      (req_vaddr_i),
    .base_i       (base_q),
    .offset_o     (off_d),
    .entry_addr_o (entry_d)
  );

  vx_pte_eval #(
    .PAGE_BITS(PAGE_BITS), .PTE_W(PTE_W)
  ) i_eval (
    .pte_i     (mem_rdata_i),
    .write_i   (write_q),
    .offset_i  (off_q),
    .status_o  (eval_status),
    .paddr_o   (eval_paddr),
    .need_wb_o (eval_wb),
    .wb_data_o (eval_wb_data)
  );

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (base_we_i) begin
      base_q <= base_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      entry_q   <= '0;
      off_q     <= '0;
      write_q   <= 1'b0;
      wb_data_q <= '0;
      status_q  <= XS_OK;
      paddr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          entry_q <= entry_d;
          off_q   <= off_d;
          write_q <= req_write_i;
          state_q <= ST_READ;
        end
        ST_READ: if (mem_ack_i) begin
          status_q  <= eval_status;
          paddr_q   <= eval_paddr;
          wb_data_q <= eval_wb_data;
          state_q   <= eval_wb ? ST_WBACK : ST_RESP;
        end
        ST_WBACK: if (mem_ack_i) state_q <= ST_RESP;
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_READ) || (state_q == ST_WBACK);
  assign mem_we_o     = (state_q == ST_WBACK);
  assign mem_addr_o   = entry_q;
  assign mem_wdata_o  = wb_data_q;
  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_status_o = status_q;
  assign rsp_paddr_o  = paddr_q;
endmodule

// File: rtl/vpage_xlate_chk.sv
module vpage_xlate_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PTE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_status_o,
  input logic [PTE_W-1:0] rsp_paddr_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [PTE_W-1:0] mem_addr_o,
  input logic [PTE_W-1:0] mem_wdata_o,
  input logic             mem_ack_i
);
  assert_read_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_req_o && !mem_we_o);

  assert_hold_until_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_fault_zero_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_status_o != 2'b00) |-> rsp_paddr_o == '0);

  assert_wb_sets_dirty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[0] && mem_wdata_o[1]);

  assert_wb_then_resp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> rsp_valid_o);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o);

  assert_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  assert_no_code3_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_status_o != 2'b11);
endmodule

bind vpage_xlate vpage_xlate_chk #(.VA_W(VA_W), .PTE_W(PTE_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_status_o (rsp_status_o),
  .rsp_paddr_o  (rsp_paddr_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ack_i    (mem_ack_i)
);

// File: tb/test_vpage_xlate.sv
module test_vpage_xlate;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] pte;
    logic [19:0] vpn;
    logic [11:0] off;
    logic        wr;
    logic [1:0]  st;
    logic        wb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h12345001, 20'd1, 12'h0A4, 1'b0, 2'b00, 1'b0},  // R3 read RO
    '{32'hABCDE006, 20'd2, 12'h010, 1'b0, 2'b01, 1'b0},  // R4 absent
    '{32'h0F0F0003, 20'd3, 12'h800, 1'b1, 2'b10, 1'b0},  // R5 write RO
    '{32'h55555005, 20'd4, 12'h123, 1'b1, 2'b00, 1'b1},  // R6 first write
    '{32'h77777007, 20'd5, 12'hFFF, 1'b1, 2'b00, 1'b0},  // R7 already dirty
    '{32'h00001005, 20'd6, 12'h000, 1'b0, 2'b00, 1'b0},  // R7 read clean
    '{32'hFFFFF000, 20'd7, 12'h456, 1'b1, 2'b01, 1'b0},  // R4 absent beats RO
    '{32'hFFFFF005, 20'd0, 12'hFFF, 1'b1, 2'b00, 1'b1}   // R6 vpn 0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_paddr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [64];
  logic [3:0]  lat = '0;
  logic [3:0]  wait_cnt = '0;
  logic        tb_we = 1'b0;
  logic [5:0]  tb_idx = '0;
  logic [31:0] tb_data = '0;
  int          wb_cnt = 0;
  logic [31:0] wb_addr = '0;
  int          rsp_cnt = 0;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpage_xlate i_vpage_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(base_we), .base_i(base_val),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_paddr_o(rsp_paddr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  assign mem_ack   = mem_req && (wait_cnt == lat);
  assign mem_rdata = mem[mem_addr[5:0]];

  always_ff @(posedge clk) begin
    cycles <= cycles + 1;
    if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
    if (!mem_req || mem_ack) wait_cnt <= '0;
    else wait_cnt <= wait_cnt + 4'd1;
    if (tb_we) mem[tb_idx] <= tb_data;
    if (mem_req && mem_ack && mem_we) begin
      mem[mem_addr[5:0]] <= mem_wdata;
      wb_cnt  <= wb_cnt + 1;
      wb_addr <= mem_addr;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_idx = idx; tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); base_we = 1'b1; base_val = b;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic wait_rsp(output logic [1:0] st, output logic [31:0] pa);
    logic seen;
    seen = 1'b0; st = '0; pa = '0;
    for (int k = 0; k < 60; k++) begin
      if (rsp_valid) begin st = rsp_status; pa = rsp_paddr; seen = 1'b1; break; end
      @(negedge clk);
    end
    if (!seen) chk(1'b0, "R10 response timeout", 32'h0, 32'h1);
  endtask

  task automatic xlate(input logic [31:0] va, input logic wr,
                       output logic [1:0] st, output logic [31:0] pa);
    @(negedge clk); req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk); req_valid = 1'b0;
    wait_rsp(st, pa);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [1:0]  st;
    logic [31:0] pa, exp_pa, exp_mem;
    int          wb0, r0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0, "R1 reset",
        {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0, "R1 after release",
        {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);

    set_base(32'd16);
    foreach (VECS[i]) begin
      lat = 4'(i % 3);
      poke(6'(16 + VECS[i].vpn), VECS[i].pte);
      wb0 = wb_cnt;
      xlate({VECS[i].vpn, VECS[i].off}, VECS[i].wr, st, pa);
      exp_pa = (VECS[i].st == 2'b00) ? {VECS[i].pte[31:12], VECS[i].off} : 32'h0;
      chk(st == VECS[i].st, "R3/R4/R5 status", {30'd0, st}, {30'd0, VECS[i].st});
      chk(pa == exp_pa, "R3/R4/R5 paddr", pa, exp_pa);
      @(negedge clk);
      exp_mem = VECS[i].wb ? (VECS[i].pte | 32'h2) : VECS[i].pte;
      chk((wb_cnt - wb0) == (VECS[i].wb ? 1 : 0), "R6/R7 write count",
          32'(wb_cnt - wb0), {31'd0, VECS[i].wb});
      chk(mem[6'(16 + VECS[i].vpn)] == exp_mem, "R6/R7 entry", mem[6'(16 + VECS[i].vpn)], exp_mem);
      if (VECS[i].wb)
        chk(wb_addr == 32'd16 + 32'(VECS[i].vpn), "R6 write address", wb_addr, 32'd16 + 32'(VECS[i].vpn));
    end

    // R2 entry address wraps modulo 2^32
    lat = 4'd1;
    set_base(32'hFFF00010);
    poke(6'd15, 32'h2468A001);
    xlate({20'hFFFFF, 12'h3C5}, 1'b0, st, pa);
    chk(st == 2'b00 && pa == 32'h2468A3C5, "R2 wrap", pa, 32'h2468A3C5);

    // R9 base change during a walk
    set_base(32'd16);
    poke(6'd25, 32'h11111001);
    poke(6'd41, 32'h22222001);
    lat = 4'd3;
    @(negedge clk); req_valid = 1'b1; req_vaddr = {20'd9, 12'h00F}; req_write = 1'b0;
    @(negedge clk); req_valid = 1'b0; base_we = 1'b1; base_val = 32'd32;
    @(negedge clk); base_we = 1'b0;
    wait_rsp(st, pa);
    chk(pa == 32'h1111100F, "R9 in-flight keeps old base", pa, 32'h1111100F);
    xlate({20'd9, 12'h00F}, 1'b0, st, pa);
    chk(pa == 32'h2222200F, "R9 next request uses new base", pa, 32'h2222200F);

    // R8 requests while busy are ignored
    set_base(32'd16);
    poke(6'd26, 32'h33333001);
    poke(6'd27, 32'h44444001);
    lat = 4'd4;
    r0 = rsp_cnt;
    @(negedge clk); req_valid = 1'b1; req_vaddr = {20'd10, 12'h001}; req_write = 1'b0;
    @(negedge clk); req_vaddr = {20'd11, 12'h002};
    chk(req_ready == 1'b0, "R8 ready low while busy", {31'd0, req_ready}, 32'h0);
    @(negedge clk); @(negedge clk); req_valid = 1'b0;
    wait_rsp(st, pa);
    chk(pa == 32'h33333001, "R8 response belongs to first", pa, 32'h33333001);
    repeat (10) @(negedge clk);
    chk(rsp_cnt - r0 == 1, "R8/R10 single response", 32'(rsp_cnt - r0), 32'h1);

    // R10 timing with zero wait states: rsp two cycles after acceptance
    lat = 4'd0;
    @(negedge clk); req_valid = 1'b1; req_vaddr = {20'd10, 12'h000}; req_write = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    chk(rsp_valid == 1'b0 && mem_req == 1'b1, "R2 read cycle after accept", {30'd0, rsp_valid, mem_req}, 32'h1);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R10 rsp after ack", {31'd0, rsp_valid}, 32'h1);
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 one-cycle pulse", {30'd0, rsp_valid, req_ready}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule